// File: doc/BRIEF.md
# Linked-List Descriptor DMA Walker

This block is a DMA engine that follows a chain of four-word descriptors kept in system memory. Software builds the chain and marks each descriptor as owned by the engine. It then writes a base pointer and a command word. The engine fetches each descriptor in turn and checks that it owns it. It streams the referenced buffer out to a peer, or into memory from a peer, through a plain word-wide memory port. When it finishes a descriptor it writes the header word back, which hands ownership to software. On the last descriptor of a frame, that header also carries the number of descriptors the frame used, and every header carries a protocol-error flag and a data-error flag.

One parameter selects the transmit or the receive flavour. The transmit flavour reads buffer words and presents them on the transfer port. The receive flavour writes the words it is offered into the buffer. The flavour also fixes where the three sticky status flags sit in the status word. A level interrupt is raised while any enabled status flag is set.

Descriptor layout, with byte offsets from a 16-byte aligned base:
- Header word (offset 0): buffer size in bytes in bits 15:0, descriptor count in bits 21:16, spare fields in bits 28:22, protocol error in bit 29, data error in bit 30, owner in bit 31 (1 means the engine owns it).
- Offset 8: buffer address.
- Offset 12: link word. Bits 1:0 hold the frame code (bit 1 means first, bit 0 means last). Bit 2 is the address-decrement bit. Bit 3 is the end-of-frame flag enable. Bits 31:4 hold the next descriptor base.
- Offset 4 is not read.

Top module: `desc_dma_walker`

## Requirements
- R1: After reset the command word, status word, base pointer and current pointer all read 0, the interrupt is low, and no memory or transfer request is made.
- R2: A register write to address 0 with bit 31 set, while idle, starts a walk at the base pointer (register address 2, bits 3:0 ignored). Bit 31 of address 0 reads 1 while the walk is busy. Each owned descriptor moves ceil(size/4) buffer words, in address order, over the transfer port, and one word moves per cycle in which both xfer_req and xfer_ack are high.
- R3: The buffer address steps by +4 per word when link bit 2 is 0 and by -4 when it is 1.
- R4: A fetched header with bit 31 clear stops the walk with no transfer and no write-back, and the current pointer keeps that descriptor. A write to address 0 with bit 30 set, while idle, refetches from the current pointer.
- R5: The write-back header keeps bits 15:0 and 28:22 and clears bit 31. Bits 21:16 hold the frame's descriptor count on a descriptor with link bit 0 set, and 0 otherwise.
- R6: A protocol error (header bit 29 and status flag) is reported when the frame code has bit 1 set inside an open frame, or has bit 1 clear with no frame open. In the second case a new frame counting from 1 is begun.
- R7: A data error (header bit 30 and status flag) is reported when the size is not a multiple of 4. The rounded-up word count is still moved.
- R8: For the transmit flavour the status flags are end-of-frame at bit 27, protocol error at bit 29 and data error at bit 30 (receive flavour: bits 22, 24, 25). They stay set until a register write to address 1 has a 1 at that position.
- R9: The interrupt is high while end-of-frame with command bit 14, protocol error with bit 16, or data error with bit 17 are both set.
- R10: End-of-frame status is set only on completing a descriptor with link bits 0 and 3 both set.
- R11: With command bit 29 set the walk follows the link to the next descriptor. With it clear the walk stops after one descriptor and the current pointer holds the linked base.
- R12: Register address 3 reads the current descriptor base at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 status, 2 base pointer, 3 current pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write this cycle |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle as mem_addr |
| xfer_req | output | 1 | Engine offers (transmit) or wants (receive) a buffer word |
| xfer_ack | input | 1 | Peer takes or supplies the word this cycle |
| xfer_rdata | output | 32 | Buffer word toward the peer (transmit) |
| xfer_wdata | input | 32 | Buffer word from the peer (receive) |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that memory answers a read in the same cycle the address is presented. They also assume that software only issues start or resume commands while the engine is idle, and that descriptor and buffer addresses are word aligned. The bench keeps within these limits as follows. Its memory model is combinational on read. It polls the busy bit before every command. It builds every chain on 16-byte slots, with buffers on word boundaries inside separate regions. It drives the acknowledge randomly, so stalls fall at arbitrary points within a buffer.

// File: rtl/dmaw_pkg.sv
// Shared constants, walker state type and helpers for the descriptor walker.
// Assumes 32-bit words and 16-byte aligned descriptors.
package dmaw_pkg;
    localparam int WORD_W   = 32;
    localparam int SIZE_W   = 16;
    localparam int CNT_W    = 6;
    localparam int CMD_RUN    = 31;
    localparam int CMD_RESUME = 30;
    localparam int CMD_CHAIN  = 29;
    localparam int EN_DATA    = 17;
    localparam int EN_PROTO   = 16;
    localparam int EN_FRAME   = 14;

    typedef enum logic [2:0] {
        W_IDLE, W_HEAD, W_BUF, W_LINK, W_MOVE, W_BACK
    } walk_state_t;

    // Turns a link or pointer word into a 16-byte aligned base.
    function automatic logic [WORD_W-1:0] link_base(input logic [WORD_W-1:0] w);
        return {w[WORD_W-1:4], 4'b0000};
    endfunction
endpackage

// File: rtl/dmaw_frame.sv
// Frame tracker: judges each descriptor's frame code against the open-frame
// state, counts descriptors per frame and flags framing violations.
// Assumes judge and close alternate, one pair per processed descriptor.
module dmaw_frame
    import dmaw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             judge,
    input  logic [1:0]       code,
    input  logic             close,
    output logic             proto_err,
    output logic             is_last,
    output logic [CNT_W-1:0] frame_cnt
);
    logic             open_q;
    logic             last_q;
    logic             perr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             begins;

    assign begins = code[1] || !open_q;

    // Latch the verdict at judge time and update the open-frame flag at close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            last_q <= 1'b0;
            perr_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (judge) begin
                last_q <= code[0];
                perr_q <= code[1] ? open_q : !open_q;
                if (begins)
                    cnt_q <= CNT_W'(1);
                else if (cnt_q != '1)
                    cnt_q <= cnt_q + CNT_W'(1);
            end
            if (close)
                open_q <= !last_q;
        end
    end

    assign proto_err = perr_q;
    assign is_last   = last_q;
    assign frame_cnt = last_q ? cnt_q : '0;
endmodule

// File: rtl/dmaw_regs.sv
// Register file: command word, sticky write-one-to-clear status, base pointer,
// current pointer readback and the interrupt combine.
// Assumes a single-cycle write strobe; reads are combinational.
module dmaw_regs
    import dmaw_pkg::*;
#(
    parameter bit IS_RX = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic [WORD_W-1:0] curr_desc,
    input  logic              ev_frame,
    input  logic              ev_proto,
    input  logic              ev_data,
    output logic              start_cmd,
    output logic              resume_cmd,
    output logic              chain_mode,
    output logic [WORD_W-1:0] first_base,
    output logic [2:0]        stat_vec,
    output logic              irq
);
    localparam int FRAME_POS = IS_RX ? 22 : 27;
    localparam int PROTO_POS = IS_RX ? 24 : 29;
    localparam int DATA_POS  = IS_RX ? 25 : 30;

    logic [WORD_W-2:0] cmd_q;
    logic [WORD_W-1:0] base_q;
    logic [2:0]        stat_q;
    logic [2:0]        clr;
    logic [WORD_W-1:0] stat_word;

    assign start_cmd  = reg_wr && reg_addr == 2'd0 && reg_wdata[CMD_RUN];
    assign resume_cmd = reg_wr && reg_addr == 2'd0 && reg_wdata[CMD_RESUME];
    assign chain_mode = cmd_q[CMD_CHAIN];
    assign first_base = link_base(base_q);
    assign stat_vec   = stat_q;

    // Pick out the status bits a write-one-to-clear access names.
    always_comb begin
        clr = 3'b000;
        if (reg_wr && reg_addr == 2'd1)
            clr = {reg_wdata[DATA_POS], reg_wdata[PROTO_POS], reg_wdata[FRAME_POS]};
    end

    // Hold command, base pointer and sticky status; new events win over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            base_q <= '0;
            stat_q <= '0;
        end else begin
            if (reg_wr && reg_addr == 2'd0) cmd_q  <= reg_wdata[WORD_W-2:0];
            if (reg_wr && reg_addr == 2'd2) base_q <= reg_wdata;
            stat_q <= (stat_q & ~clr) | {ev_data, ev_proto, ev_frame};
        end
    end

    // Place the status flags at the flavour's bit positions.
    always_comb begin
        stat_word            = '0;
        stat_word[FRAME_POS] = stat_q[0];
        stat_word[PROTO_POS] = stat_q[1];
        stat_word[DATA_POS]  = stat_q[2];
    end

    // Register read multiplexer.
    always_comb begin
        unique case (reg_addr)
            2'd0:    reg_rdata = {busy, cmd_q};
            2'd1:    reg_rdata = stat_word;
            2'd2:    reg_rdata = base_q;
            default: reg_rdata = curr_desc;
        endcase
    end

    assign irq = (stat_q[0] && cmd_q[EN_FRAME]) ||
                 (stat_q[1] && cmd_q[EN_PROTO]) ||
                 (stat_q[2] && cmd_q[EN_DATA]);
endmodule

// File: rtl/dmaw_walker.sv
// Descriptor walker: fetches header, buffer address and link, moves the
// buffer one word per acknowledged cycle, then writes the header back.
// Assumes memory read data is valid in the cycle the address is driven.
module dmaw_walker
    import dmaw_pkg::*;
#(
    parameter bit IS_RX = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_cmd,
    input  logic              resume_cmd,
    input  logic              chain_mode,
    input  logic [WORD_W-1:0] first_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              xfer_req,
    input  logic              xfer_ack,
    input  logic [WORD_W-1:0] xfer_wdata,
    output logic              busy,
    output logic              wb_phase,
    output logic [WORD_W-1:0] curr_desc,
    output logic              ev_frame,
    output logic              ev_proto,
    output logic              ev_data
);
    localparam int KEEP_W = SIZE_W + 7;
    localparam int LEFT_W = SIZE_W - 1;

    walk_state_t       st_q;
    logic [WORD_W-1:0] ptr_q;
    logic [WORD_W-1:0] bufa_q;
    logic [WORD_W-1:0] link_q;
    logic [KEEP_W-1:0] keep_q;
    logic [LEFT_W-1:0] left_q;
    logic              derr_q;
    logic [SIZE_W:0]   rounded;
    logic              f_perr;
    logic              f_last;
    logic [CNT_W-1:0]  f_cnt;

    assign rounded = {1'b0, keep_q[SIZE_W-1:0]} + (SIZE_W+1)'(3);

    dmaw_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .judge     (st_q == W_LINK),
        .code      (mem_rdata[1:0]),
        .close     (st_q == W_BACK),
        .proto_err (f_perr),
        .is_last   (f_last),
        .frame_cnt (f_cnt)
    );

    // Sequence through fetch, move and write-back for each descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= W_IDLE;
            ptr_q  <= '0;
            bufa_q <= '0;
            link_q <= '0;
            keep_q <= '0;
            left_q <= '0;
            derr_q <= 1'b0;
        end else begin
            unique case (st_q)
                W_IDLE: begin
                    if (start_cmd) begin
                        ptr_q <= first_base;
                        st_q  <= W_HEAD;
                    end else if (resume_cmd) begin
                        st_q <= W_HEAD;
                    end
                end
                W_HEAD: begin
                    keep_q <= {mem_rdata[28:22], mem_rdata[SIZE_W-1:0]};
                    st_q   <= mem_rdata[31] ? W_BUF : W_IDLE;
                end
                W_BUF: begin
                    bufa_q <= mem_rdata;
                    st_q   <= W_LINK;
                end
                W_LINK: begin
                    link_q <= mem_rdata;
                    left_q <= rounded[SIZE_W:2];
                    derr_q <= keep_q[1:0] != 2'b00;
                    st_q   <= (rounded[SIZE_W:2] == '0) ? W_BACK : W_MOVE;
                end
                W_MOVE: begin
                    if (xfer_ack) begin
                        bufa_q <= link_q[2] ? bufa_q - WORD_W'(4) : bufa_q + WORD_W'(4);
                        left_q <= left_q - LEFT_W'(1);
                        if (left_q == LEFT_W'(1)) st_q <= W_BACK;
                    end
                end
                default: begin
                    ptr_q <= link_base(link_q);
                    st_q  <= chain_mode ? W_HEAD : W_IDLE;
                end
            endcase
        end
    end

    // Drive the memory and transfer ports for the current phase.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr_q;
        mem_wdata = '0;
        xfer_req  = 1'b0;
        unique case (st_q)
            W_HEAD: mem_req = 1'b1;
            W_BUF: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q + WORD_W'(8);
            end
            W_LINK: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q + WORD_W'(12);
            end
            W_MOVE: begin
                xfer_req  = 1'b1;
                mem_addr  = bufa_q;
                mem_req   = IS_RX ? xfer_ack : 1'b1;
                mem_we    = IS_RX ? xfer_ack : 1'b0;
                mem_wdata = IS_RX ? xfer_wdata : '0;
            end
            W_BACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {1'b0, derr_q, f_perr, keep_q[KEEP_W-1:SIZE_W],
                             f_cnt, keep_q[SIZE_W-1:0]};
            end
            default: ;
        endcase
    end

    assign busy      = st_q != W_IDLE;
    assign wb_phase  = st_q == W_BACK;
    assign curr_desc = ptr_q;
    assign ev_frame  = wb_phase && f_last && link_q[3];
    assign ev_proto  = wb_phase && f_perr;
    assign ev_data   = wb_phase && derr_q;
endmodule

// File: rtl/desc_dma_walker.sv
// Top level: register file plus descriptor walker. IS_RX picks the receive
// flavour (buffer written from the transfer port) and its status positions.
// Assumes a combinational-read word memory on the mem_* port.
module desc_dma_walker
    import dmaw_pkg::*;
#(
    parameter bit IS_RX = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              xfer_req,
    input  logic              xfer_ack,
    output logic [WORD_W-1:0] xfer_rdata,
    input  logic [WORD_W-1:0] xfer_wdata,
    output logic              irq
);
    logic              start_cmd, resume_cmd, chain_mode;
    logic              busy, wb_phase;
    logic              ev_frame, ev_proto, ev_data;
    logic [WORD_W-1:0] first_base, curr_desc;
    logic [2:0]        stat_vec;

    assign xfer_rdata = mem_rdata;

    dmaw_regs #(.IS_RX(IS_RX)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .curr_desc  (curr_desc),
        .ev_frame   (ev_frame),
        .ev_proto   (ev_proto),
        .ev_data    (ev_data),
        .start_cmd  (start_cmd),
        .resume_cmd (resume_cmd),
        .chain_mode (chain_mode),
        .first_base (first_base),
        .stat_vec   (stat_vec),
        .irq        (irq)
    );

    dmaw_walker #(.IS_RX(IS_RX)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_cmd  (start_cmd),
        .resume_cmd (resume_cmd),
        .chain_mode (chain_mode),
        .first_base (first_base),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .xfer_req   (xfer_req),
        .xfer_ack   (xfer_ack),
        .xfer_wdata (xfer_wdata),
        .busy       (busy),
        .wb_phase   (wb_phase),
        .curr_desc  (curr_desc),
        .ev_frame   (ev_frame),
        .ev_proto   (ev_proto),
        .ev_data    (ev_data)
    );
endmodule

// File: rtl/dmaw_checker.sv
// Property checker for desc_dma_walker, attached by bind below.
// Assumes commands are issued only while idle and memory reads are same-cycle.
module dmaw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic        busy,
    input logic        wb_phase,
    input logic        start_cmd,
    input logic [31:0] first_base,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        xfer_req,
    input logic [2:0]  stat_vec,
    input logic        irq
);
    // R1: an idle engine touches neither memory nor the transfer port.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !xfer_req));

    // R2: a start while idle fetches the header at the base pointer next cycle.
    p_start_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cmd && !busy) |=> (mem_req && !mem_we && mem_addr == $past(first_base)));

    // R5: the header write-back always returns ownership to software.
    p_own_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_phase |-> (mem_we && !mem_wdata[31]));

    // R8: a set status flag survives every cycle without a status write.
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 2'd1) |=> (($past(stat_vec) & ~stat_vec) == 3'b000));

    // R9: the interrupt can only rise after a write-back or a register write.
    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wb_phase || reg_wr));
endmodule

bind desc_dma_walker dmaw_checker u_dmaw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .busy       (busy),
    .wb_phase   (wb_phase),
    .start_cmd  (start_cmd),
    .first_base (first_base),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .xfer_req   (xfer_req),
    .stat_vec   (stat_vec),
    .irq        (irq)
);

// File: tb/desc_dma_walker_bench.sv
module desc_dma_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        xfer_req;
    logic        xfer_ack = 1'b0;
    logic [31:0] xfer_rdata;
    logic [31:0] xfer_wdata = '0;
    logic        irq;

    logic [31:0] mem [0:1023];
    logic [31:0] exp_q[$];
    logic [31:0] got_q[$];
    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    desc_dma_walker #(.IS_RX(1'b0)) u_desc_dma_walker (.*);

    assign mem_rdata = mem[mem_addr[11:2]];
    always @(posedge clk) if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
    always @(posedge clk) if (xfer_req && xfer_ack) got_q.push_back(xfer_rdata);
    always @(negedge clk) xfer_ack <= ($urandom % 4) != 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            rd(2'd0, v);
            if (!v[31]) break;
        end
    endtask

    // Expected write-back header from the requirements (R5, R6, R7).
    function automatic logic [31:0] wb_word(input logic [31:0] h, input bit pe,
                                            input bit de, input int cnt);
        return {1'b0, de, pe, h[28:22], 6'(cnt), h[15:0]};
    endfunction

    // Places a descriptor in a 16-byte slot.
    task automatic put_desc(input int slot, input logic [31:0] hdr,
                            input logic [31:0] bufa, input logic [31:0] lnk);
        mem[slot*4]   = hdr;
        mem[slot*4+1] = 32'hDEAD_0000;
        mem[slot*4+2] = bufa;
        mem[slot*4+3] = lnk;
    endtask

    function automatic logic [31:0] hdr_of(input bit own, input int size);
        return {own, 2'b00, 7'($urandom), 6'($urandom), 16'(size)};
    endfunction

    // One random chain of framed descriptors ending on a CPU-owned slot.
    task automatic random_round(input int r);
        int n = 2 + ($urandom % 4);
        int base = r * 8;
        int flen = 0, fpos = 0;
        bit eof_exp = 0;
        logic [31:0] hdrs[8];
        int cnts[8];
        logic [31:0] v;
        exp_q.delete(); got_q.delete();
        for (int d = 0; d < n; d++) begin
            int size = 4 * ($urandom % 7);
            bit dec = (d == 0) ? 1'b1 : 1'($urandom);
            bit eofie = 1'($urandom);
            int wbase = 512 + (base + d) * 8;
            int start_w = dec ? wbase + 7 : wbase;
            bit first, last;
            if (fpos == 0) begin
                flen = 1 + ($urandom % 3);
                if (flen > n - d) flen = n - d;
            end
            first = (fpos == 0);
            last = (fpos == flen - 1);
            cnts[d] = last ? flen : 0;
            fpos = last ? 0 : fpos + 1;
            if (last && eofie) eof_exp = 1;
            for (int k = 0; k < 8; k++) mem[wbase + k] = $urandom;
            for (int k = 0; k < size / 4; k++)
                exp_q.push_back(mem[dec ? start_w - k : start_w + k]);
            hdrs[d] = hdr_of(1'b1, size);
            put_desc(base + d, hdrs[d], 32'(start_w * 4),
                     {28'(base + d + 1), eofie, dec, first, last});
        end
        put_desc(base + n, hdr_of(1'b0, 4), 32'h0, 32'h0);
        wr(2'd2, 32'(base * 16));
        wr(2'd0, 32'hA000_0000);
        wait_idle();
        check($sformatf("R2 words moved round %0d", r), got_q.size(), exp_q.size());
        for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
            check($sformatf("R2/R3 word %0d round %0d", k, r), got_q[k], exp_q[k]);
        for (int d = 0; d < n; d++)
            check($sformatf("R5 writeback desc %0d round %0d", d, r),
                  mem[(base + d) * 4], wb_word(hdrs[d], 0, 0, cnts[d]));
        rd(2'd3, v);
        check("R12 current pointer at stop", v, 32'((base + n) * 16));
        rd(2'd1, v);
        check("R10 end-of-frame status", v, eof_exp ? 32'h0800_0000 : 32'h0);
        wr(2'd1, 32'hFFFF_FFFF);
    endtask

    initial begin
        logic [31:0] v, h;
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        rd(2'd0, v); check("R1 command after reset", v, 0);
        rd(2'd1, v); check("R1 status after reset", v, 0);
        rd(2'd2, v); check("R1 base after reset", v, 0);
        rd(2'd3, v); check("R1 current after reset", v, 0);
        check("R1 irq after reset", {31'b0, irq}, 0);

        // R2, R3, R5, R10, R11, R12: random framed chains
        for (int r = 0; r < 4; r++) random_round(r);

        // R4: stall on a CPU-owned descriptor, then resume
        got_q.delete();
        h = hdr_of(1'b0, 8);
        mem[600] = 32'h1111_0001; mem[601] = 32'h2222_0002;
        put_desc(40, h, 32'd2400, {28'd41, 4'b0011});
        put_desc(41, hdr_of(1'b0, 4), 0, 0);
        wr(2'd2, 32'd640);
        wr(2'd0, 32'hA000_0000);
        wait_idle();
        rd(2'd3, v); check("R4 stalled pointer", v, 32'd640);
        check("R4 nothing moved on stall", got_q.size(), 0);
        check("R4 header untouched on stall", mem[160], h);
        h[31] = 1'b1; mem[160] = h;
        wr(2'd0, 32'h6000_0000);
        wait_idle();
        check("R4 words after resume", got_q.size(), 2);
        if (got_q.size() == 2) begin
            check("R4 first word after resume", got_q[0], 32'h1111_0001);
            check("R4 second word after resume", got_q[1], 32'h2222_0002);
        end
        rd(2'd3, v); check("R4 pointer after resume", v, 32'd656);

        // R6, R7, R8, R9: lone last-only descriptor, size 6, no frame open
        got_q.delete();
        h = hdr_of(1'b1, 6);
        put_desc(44, h, 32'd2560, {28'd45, 4'b1001});
        put_desc(45, hdr_of(1'b0, 4), 0, 0);
        wr(2'd2, 32'd704);
        wr(2'd0, 32'hA001_0000);
        wait_idle();
        check("R7 rounded word count", got_q.size(), 2);
        check("R6/R7 error write-back", mem[176], wb_word(h, 1, 1, 1));
        rd(2'd1, v); check("R8 status flag positions", v, 32'h6800_0000);
        check("R9 irq with protocol enable", {31'b0, irq}, 1);
        wr(2'd1, 32'h2000_0000);
        rd(2'd1, v); check("R8 clear only named flag", v, 32'h4800_0000);
        check("R9 irq low after clear", {31'b0, irq}, 0);
        wr(2'd0, 32'h2002_0000);
        check("R9 irq with data enable", {31'b0, irq}, 1);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); check("R8 all cleared", v, 0);
        check("R9 irq low with no flags", {31'b0, irq}, 0);

        // R11, R10: single-descriptor mode, no end-of-frame enable
        got_q.delete();
        put_desc(48, hdr_of(1'b1, 4), 32'd2800, {28'd49, 4'b0011});
        h = hdr_of(1'b1, 4);
        put_desc(49, h, 32'd2804, {28'd50, 4'b0011});
        put_desc(50, hdr_of(1'b0, 4), 0, 0);
        wr(2'd2, 32'd768);
        wr(2'd0, 32'h8000_0000);
        wait_idle();
        check("R11 one descriptor in single mode", got_q.size(), 1);
        rd(2'd3, v); check("R11 pointer at linked base", v, 32'd784);
        check("R11 next descriptor still owned", mem[196], h);
        wr(2'd0, 32'h4000_0000);
        wait_idle();
        check("R11 second step moved one word", got_q.size(), 2);
        rd(2'd3, v); check("R11 pointer after second step", v, 32'd800);
        rd(2'd1, v); check("R10 no end-of-frame without enable", v, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule